// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects three interrupt sources for a small processor core: a falling edge on an external, active-low interrupt pin, an overflow pulse from the sampling-rate counter and an overflow pulse from the timer/event counter. Each source has a request flag that stays set until the request is serviced or software clears it. A single 8-bit control/status register holds those flags, a per-source enable for each and a master enable.

The core raises a sample strobe once per instruction cycle. On a strobe cycle the block looks at the register. It grants the most urgent source that is enabled and pending, provided the master enable is on and the return stack has room. The grant appears as a one-cycle acknowledge pulse, together with a 2-bit vector select that the core turns into the service address.

Granting a source clears the master enable and that source's flag. Further nesting therefore needs software to set the master enable again. A return-from-interrupt indication sets the master enable again, and a plain return does not. Saving the core's context and sequencing its pipeline are left to the core.

Top module: `vec_irq_ctrl`

## Requirements
- R1: The register reads 0x00 after reset. Bit 0 is the master enable. Bits 1, 2 and 3 enable the external, sampling-rate and timer sources. Bits 4, 5 and 6 are the request flags of the same three sources. A write stores bits 0 to 6, which read back from the next cycle on. Bit 7 always reads 0, even after a 1 is written to it.
- R2: The external pin passes through a two-flop synchronizer. A high-to-low pin change that is sampled at clock edge k sets bit 4, visible after edge k+2. A low-to-high change sets no flag.
- R3: A one-cycle sampling-rate overflow pulse sets bit 5 at the next edge. A one-cycle timer overflow pulse sets bit 6 at the next edge.
- R4: A source is granted only in a cycle where the strobe is high, the master enable, the source enable and the source flag are all 1, and the stack has room. The acknowledge output is high for exactly the one cycle after that strobe cycle.
- R5: At the edge where the acknowledge rises, the master enable and the granted source's flag are cleared. The other flags and all enables keep their values.
- R6: When several sources qualify together, the external source wins, the sampling-rate source comes second and the timer source comes third. The vector select is 1, 2 or 3 for these sources, which is vector address 04H, 08H or 0CH when multiplied by 4. It is 0 whenever the acknowledge is low.
- R7: A return-from-interrupt pulse sets the master enable at the next edge. A plain return pulse changes no register bit. If a grant happens in the same cycle as a return-from-interrupt pulse, the grant's clear of the master enable takes precedence.
- R8: A cycle in which a return or return-from-interrupt pulse is high counts as having stack room, even while the stack-full input is high.
- R9: Flags set between strobes stay set through any number of non-strobe cycles and are evaluated at the next strobe.
- R10: When a hardware event sets a flag in the same cycle as a register write that clears that flag, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pin_n | input | 1 | External interrupt pin, asynchronous, active-low (falling edge) |
| srate_ovf | input | 1 | Sampling-rate counter overflow pulse |
| tmr_ovf | input | 1 | Timer/event counter overflow pulse |
| t2_strobe | input | 1 | Once-per-instruction evaluation strobe |
| stack_full | input | 1 | Return stack has no free entry |
| reti | input | 1 | Return-from-interrupt executing (pops the stack) |
| ret | input | 1 | Plain return executing (pops the stack) |
| reg_we | input | 1 | Control/status register write enable |
| reg_wdata | input | 8 | Control/status register write data |
| reg_rdata | output | 8 | Control/status register read value |
| ack | output | 1 | Interrupt acknowledge pulse |
| vec_sel | output | 2 | Vector select (1 external, 2 sampling-rate, 3 timer) |

## Verification
The bench builds the block with the default two-stage synchronizer and the fixed three sources. At these values the exact pin-to-flag latency can be checked, and every priority pairing can be reached, including the lowest-priority timer source after the two higher ones have been served. Directed phases set up the precedence collisions: a grant together with a return-from-interrupt, a hardware set together with a software clear, and a full stack together with a return. A long phase of random stimulus then interleaves strobes, pin edges and writes in orders that no directed phase covers.

// File: rtl/vic_pkg.sv
package vic_pkg;

    localparam int NSRC   = 3;
    localparam int REG_W  = 8;
    localparam int VSEL_W = $clog2(NSRC + 1);

    localparam int SRC_EXT   = 0;
    localparam int SRC_SRATE = 1;
    localparam int SRC_TMR   = 2;

    // Packed from MSB: reserved, flags[2:0] (bits 6:4), enables[2:0] (bits 3:1), master (bit 0)
    typedef struct packed {
        logic            rsvd;
        logic [NSRC-1:0] flag;
        logic [NSRC-1:0] en;
        logic            master;
    } ctrl_t;

    // Lowest index (highest priority) set bit, one-hot
    function automatic logic [NSRC-1:0] first_one(input logic [NSRC-1:0] req);
        logic [NSRC-1:0] oh;
        logic            found;
        oh    = '0;
        found = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (req[i] && !found) begin
                oh[i] = 1'b1;
                found = 1'b1;
            end
        end
        return oh;
    endfunction

    // Vector select for a one-hot grant: source index plus one, 0 when idle
    function automatic logic [VSEL_W-1:0] vsel_of(input logic [NSRC-1:0] oh);
        logic [VSEL_W-1:0] v;
        v = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (oh[i]) v = VSEL_W'(i + 1);
        end
        return v;
    endfunction

endpackage

// File: rtl/vic_edge_sync.sv
module vic_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic fall
);
    localparam int LAST = STAGES;

    // chain[0..STAGES-1]: synchronizer flops, chain[STAGES]: previous synchronized value
    logic [LAST:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '1;
        end else begin
            chain <= {chain[LAST-1:0], pin};
        end
    end

    assign fall = chain[LAST] & ~chain[LAST-1];
endmodule

// File: rtl/vic_prio_arb.sv
module vic_prio_arb
    import vic_pkg::*;
(
    input  ctrl_t           ctrl,
    input  logic            strobe,
    input  logic            stack_full,
    input  logic            pop,
    output logic [NSRC-1:0] grant
);
    logic            room;
    logic [NSRC-1:0] ready;

    assign room  = ~stack_full | pop;
    assign ready = ctrl.en & ctrl.flag;

    always_comb begin
        grant = '0;
        if (strobe && ctrl.master && room) begin
            grant = first_one(ready);
        end
    end
endmodule

// File: rtl/vic_ctrl_reg.sv
module vic_ctrl_reg
    import vic_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    input  logic [NSRC-1:0]  hw_set,
    input  logic [NSRC-1:0]  grant,
    input  logic             reti,
    output ctrl_t            q
);
    ctrl_t d;

    // Precedence, lowest first: software write, return-from-interrupt,
    // grant clear, hardware flag set.
    always_comb begin
        d = q;
        if (we) begin
            d = ctrl_t'(wdata);
        end
        d.rsvd = 1'b0;
        if (reti) begin
            d.master = 1'b1;
        end
        if (|grant) begin
            d.master = 1'b0;
        end
        d.flag = (d.flag & ~grant) | hw_set;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
    import vic_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              irq_pin_n,
    input  logic              srate_ovf,
    input  logic              tmr_ovf,
    input  logic              t2_strobe,
    input  logic              stack_full,
    input  logic              reti,
    input  logic              ret,
    input  logic              reg_we,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              ack,
    output logic [VSEL_W-1:0] vec_sel
);
    ctrl_t           ctrl_q;
    logic            ext_fall;
    logic [NSRC-1:0] hw_set;
    logic [NSRC-1:0] grant;
    logic            pop;

    vic_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .pin  (irq_pin_n),
        .fall (ext_fall)
    );

    always_comb begin
        hw_set            = '0;
        hw_set[SRC_EXT]   = ext_fall;
        hw_set[SRC_SRATE] = srate_ovf;
        hw_set[SRC_TMR]   = tmr_ovf;
    end

    assign pop = ret | reti;

    vic_prio_arb u_arb (
        .ctrl       (ctrl_q),
        .strobe     (t2_strobe),
        .stack_full (stack_full),
        .pop        (pop),
        .grant      (grant)
    );

    vic_ctrl_reg u_reg (
        .clk    (clk),
        .rst    (rst),
        .we     (reg_we),
        .wdata  (reg_wdata),
        .hw_set (hw_set),
        .grant  (grant),
        .reti   (reti),
        .q      (ctrl_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ack     <= 1'b0;
            vec_sel <= '0;
        end else begin
            ack     <= |grant;
            vec_sel <= vsel_of(grant);
        end
    end

    assign reg_rdata = REG_W'(ctrl_q);
endmodule

// File: rtl/vic_chk.sv
module vic_chk (
    input logic       clk,
    input logic       rst,
    input logic       t2_strobe,
    input logic       reti,
    input logic       reg_we,
    input logic       tmr_ovf,
    input logic       ack,
    input logic [1:0] vec_sel,
    input logic [7:0] reg_rdata
);
    AST_BIT7_ZERO: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[7] == 1'b0); // R1

    AST_OVF_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && tmr_ovf) |-> reg_rdata[6]); // R3

    AST_ACK_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
        ack |-> $past(t2_strobe && reg_rdata[0])); // R4

    AST_ACK_CLEARS_MASTER: assert property (@(posedge clk) disable iff (rst)
        ack |-> !reg_rdata[0]); // R5

    AST_VSEL_IDLE: assert property (@(posedge clk) disable iff (rst)
        !ack |-> vec_sel == 2'd0); // R6

    AST_VSEL_VALID: assert property (@(posedge clk) disable iff (rst)
        ack |-> vec_sel != 2'd0); // R6

    AST_EXT_FIRST: assert property (@(posedge clk) disable iff (rst)
        (ack && $past(!rst && reg_rdata[4] && reg_rdata[1])) |-> vec_sel == 2'd1); // R6

    AST_RETI_MASTER: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst && reti) && !ack) |-> reg_rdata[0]); // R7

    AST_FLAG_HELD: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && reg_rdata[6] && !reg_we) |-> (reg_rdata[6] || (ack && vec_sel == 2'd3))); // R9
endmodule

bind vec_irq_ctrl vic_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .t2_strobe (t2_strobe),
    .reti      (reti),
    .reg_we    (reg_we),
    .tmr_ovf   (tmr_ovf),
    .ack       (ack),
    .vec_sel   (vec_sel),
    .reg_rdata (reg_rdata)
);

// File: tb/vec_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module vec_irq_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       irq_pin_n = 1'b1;
    logic       srate_ovf = 1'b0;
    logic       tmr_ovf = 1'b0;
    logic       t2_strobe = 1'b0;
    logic       stack_full = 1'b0;
    logic       reti = 1'b0;
    logic       ret = 1'b0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       ack;
    logic [1:0] vec_sel;

    int    compared   = 0;
    int    mismatched = 0;
    string cur_req    = "R1";
    bit    done       = 1'b0;

    always #2.5 clk = ~clk;

    vec_irq_ctrl dut_i (
        .clk        (clk),
        .rst        (rst),
        .irq_pin_n  (irq_pin_n),
        .srate_ovf  (srate_ovf),
        .tmr_ovf    (tmr_ovf),
        .t2_strobe  (t2_strobe),
        .stack_full (stack_full),
        .reti       (reti),
        .ret        (ret),
        .reg_we     (reg_we),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .ack        (ack),
        .vec_sel    (vec_sel)
    );

    // Behavioural reference model, updated at each rising edge
    bit       m_master;
    bit [2:0] m_en;
    bit [2:0] m_flag;
    bit       m_ack;
    bit [1:0] m_vsel;
    bit       hist[$];

    always @(posedge clk) begin
        if (rst) begin
            m_master = 1'b0;
            m_en     = 3'b000;
            m_flag   = 3'b000;
            m_ack    = 1'b0;
            m_vsel   = 2'd0;
            hist     = '{1'b1, 1'b1, 1'b1};
        end else begin
            int g;
            bit fall;
            g = -1;
            if (t2_strobe && m_master && (!stack_full || ret || reti)) begin
                for (int i = 0; i < 3; i++) begin
                    if (g < 0 && m_en[i] && m_flag[i]) g = i;
                end
            end
            fall = hist[2] && !hist[1];
            if (reg_we) begin
                m_master = reg_wdata[0];
                m_en     = reg_wdata[3:1];
                m_flag   = reg_wdata[6:4];
            end
            if (reti) m_master = 1'b1;
            if (g >= 0) begin
                m_master  = 1'b0;
                m_flag[g] = 1'b0;
            end
            if (fall)      m_flag[0] = 1'b1;
            if (srate_ovf) m_flag[1] = 1'b1;
            if (tmr_ovf)   m_flag[2] = 1'b1;
            m_ack  = (g >= 0);
            m_vsel = (g >= 0) ? 2'(g + 1) : 2'd0;
            hist.push_front(irq_pin_n);
            void'(hist.pop_back());
        end
    end

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string what);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(reg_rdata, {1'b0, m_flag, m_en, m_master}, "reg_rdata");
            chk({7'd0, ack}, {7'd0, m_ack}, "ack");
            chk({6'd0, vec_sel}, {6'd0, m_vsel}, "vec_sel");
        end
    end

    task automatic report();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk);
        reg_we    = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic strobe_once();
        @(negedge clk);
        t2_strobe = 1'b1;
        @(negedge clk);
        t2_strobe = 1'b0;
    endtask

    task automatic reti_once();
        @(negedge clk);
        reti = 1'b1;
        @(negedge clk);
        reti = 1'b0;
    endtask

    task automatic ret_once();
        @(negedge clk);
        ret = 1'b1;
        @(negedge clk);
        ret = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL %s watchdog: actual running expected finished", cur_req);
            report();
        end
    end

    initial begin
        idle(3);
        rst = 1'b0;

        // R1: reset value, layout, bit 7 stays 0
        cur_req = "R1";
        idle(3);
        wr(8'hFF);
        idle(2);
        wr(8'h2A);
        wr(8'h00);

        // R2: falling edge sets external flag, rising edge does not
        cur_req = "R2";
        @(negedge clk);
        irq_pin_n = 1'b0;
        idle(5);
        wr(8'h00);
        irq_pin_n = 1'b1;
        idle(5);

        // R3: overflow pulses set their flags
        cur_req = "R3";
        @(negedge clk); srate_ovf = 1'b1;
        @(negedge clk); srate_ovf = 1'b0;
        idle(2);
        @(negedge clk); tmr_ovf = 1'b1;
        @(negedge clk); tmr_ovf = 1'b0;
        idle(2);
        wr(8'h00);

        // R4: gating by master, stack room and strobe
        cur_req = "R4";
        wr(8'h7E);
        strobe_once();
        idle(2);
        wr(8'h7F);
        idle(3);
        stack_full = 1'b1;
        strobe_once();
        idle(2);
        stack_full = 1'b0;
        strobe_once();
        idle(2);

        // R5: grant clears master and served flag only
        cur_req = "R5";
        wr(8'h5B);
        strobe_once();
        idle(3);

        // R6: priority order and vector select values
        cur_req = "R6";
        wr(8'h7F);
        for (int k = 0; k < 3; k++) begin
            strobe_once();
            idle(2);
            reti_once();
            idle(1);
        end

        // R7: ret leaves master alone, reti sets it, grant beats reti
        cur_req = "R7";
        wr(8'h00);
        ret_once();
        idle(2);
        reti_once();
        idle(2);
        wr(8'h13);
        @(negedge clk);
        t2_strobe = 1'b1;
        reti      = 1'b1;
        @(negedge clk);
        t2_strobe = 1'b0;
        reti      = 1'b0;
        idle(2);

        // R8: a return pulse frees a stack entry for the grant
        cur_req = "R8";
        wr(8'h13);
        stack_full = 1'b1;
        @(negedge clk);
        t2_strobe = 1'b1;
        ret       = 1'b1;
        @(negedge clk);
        t2_strobe = 1'b0;
        ret       = 1'b0;
        stack_full = 1'b0;
        idle(2);

        // R9: pending flag survives many cycles without a strobe
        cur_req = "R9";
        wr(8'h4F);
        idle(12);
        strobe_once();
        idle(2);

        // R10: hardware set beats software clear
        cur_req = "R10";
        wr(8'h0E);
        @(negedge clk);
        reg_we    = 1'b1;
        reg_wdata = 8'h0E;
        tmr_ovf   = 1'b1;
        srate_ovf = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
        tmr_ovf   = 1'b0;
        srate_ovf = 1'b0;
        idle(2);

        // Random mix, priority and precedence under interleaving
        cur_req = "R6";
        for (int n = 0; n < 4000; n++) begin
            @(negedge clk);
            if ($urandom_range(0, 7) == 0) irq_pin_n = ~irq_pin_n;
            srate_ovf  = ($urandom_range(0, 15) == 0);
            tmr_ovf    = ($urandom_range(0, 15) == 0);
            t2_strobe  = ($urandom_range(0, 3) == 0);
            stack_full = ($urandom_range(0, 3) == 0);
            reti       = ($urandom_range(0, 15) == 0);
            ret        = ($urandom_range(0, 31) == 0);
            reg_we     = ($urandom_range(0, 31) == 0);
            reg_wdata  = 8'($urandom_range(0, 255));
        end
        @(negedge clk);
        srate_ovf = 1'b0; tmr_ovf = 1'b0; t2_strobe = 1'b0;
        stack_full = 1'b0; reti = 1'b0; ret = 1'b0; reg_we = 1'b0;
        idle(4);

        report();
    end

endmodule